// File: doc/BRIEF.md
# Microwire Serial EEPROM Slave

This block is a synthesizable behavioural model of a small serial EEPROM that sits on a three-wire Microwire bus. A host drives a chip select, a serial clock and a serial data line. The block returns data on a serial output that it drives only when it has something to say, and reports that state on a separate output-enable. The chip's system clock oversamples all bus inputs, so the serial clock may run at any rate well below the system clock.

The array holds 1024 bits. A static organisation input presents them either as 64 words of 16 bits or as 128 bytes of 8 bits. Seven commands are decoded:
- read, with continuous streaming through higher addresses;
- single-location write and erase;
- whole-array write and erase;
- write enable and write disable.

Programming commands are armed by a complete frame and start on the next chip-select falling edge. They are then followed by a self-timed busy window whose length is a parameter. While that window is open, raising chip select shows busy or ready on the serial output.

Top module: `mw_eeprom`

## Requirements
- R1: A frame begins with the first 1 sampled on DIN at a rising SK while CS is high. Leading 0 bits are skipped. The start bit is followed by a 2-bit opcode and then an address of 6 bits (x16) or 7 bits (x8), MSB first.
- R2: With `org_i` high the array is 64 x 16 bits. With it low it is 128 x 8 bits. Byte address b maps to word b>>1: the low byte when b[0]=0 and the high byte when b[0]=1.
- R3: Opcode 10 reads, 01 writes and 11 erases one location. Opcode 00 is qualified by the top two address bits: 11 enables programming, 00 disables it, 01 writes the following data word to every location, and 10 erases every location.
- R4: After the last address bit of a read, DOUT is driven and shows a single 0. Each later rising SK shifts out the addressed word MSB first.
- R5: A read that keeps CS high continues with the next higher location without a gap. After the last location it wraps to location 0.
- R6: After reset programming is disabled. Write, erase, write-all and erase-all change nothing unless an enable has been decoded since the last disable.
- R7: Programming starts at the CS falling edge that follows a frame of exactly the required length. A write stores its data word (16 or 8 bits, MSB first) at the address.
- R8: Erase sets every bit of the addressed location to 1. Erase-all sets the whole array to 1.
- R9: Once programming starts, the block stays busy for `BUSY_CYCLES` system clocks. If CS is high during that time, DOUT is driven 0 while busy and 1 once ready.
- R10: A rising SK with CS high and DIN high clears the busy/ready indication. DOUT is then released unless a read is in progress.
- R11: Any bit clocked in beyond a command's length cancels a pending write, erase, write-all or erase-all. Enable, disable and read still take effect.
- R12: While busy, start bits are ignored, so a complete command sent during the busy window has no effect.
- R13: While CS is low, `dout_oe_o` is 0. After reset every location reads as all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that oversamples the bus |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cs_i | input | 1 | Bus chip select, active high |
| sk_i | input | 1 | Bus serial clock |
| din_i | input | 1 | Serial data into the block |
| org_i | input | 1 | Organisation: 1 = 64x16, 0 = 128x8 (held static) |
| dout_o | output | 1 | Serial data or busy/ready status out |
| dout_oe_o | output | 1 | Output enable for `dout_o`; 0 means high impedance |

## Verification
On every cycle the assertions check three things. Programming only launches in the first system cycle after chip select has dropped. A launch always opens the busy window, and an idle timer never goes busy on its own. The storage never changes in a cycle without a launch.

Behaviour that depends on whole serial frames can only be shown by the bench's scenarios. This covers the dummy bit and MSB-first order of reads, streaming across the array end in both organisations, and the byte-lane mapping between x8 and x16. It also covers cancellation by trailing bits, write protection, the busy/ready display and its clearing, and commands dropped during the busy window.

// File: rtl/mw_pkg.sv
package mw_pkg;

  typedef enum logic [2:0] {
    ST_WAIT,
    ST_HDR,
    ST_DATA,
    ST_TAIL,
    ST_READ
  } fr_state_e;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_WRITE,
    OP_ERASE,
    OP_WRALL,
    OP_ERAL
  } prog_op_e;

  localparam logic [1:0] OPC_EXT   = 2'b00;
  localparam logic [1:0] OPC_WRITE = 2'b01;
  localparam logic [1:0] OPC_READ  = 2'b10;
  localparam logic [1:0] OPC_ERASE = 2'b11;

  localparam logic [1:0] SUB_WDS   = 2'b00;
  localparam logic [1:0] SUB_WRALL = 2'b01;
  localparam logic [1:0] SUB_ERAL  = 2'b10;
  localparam logic [1:0] SUB_WEN   = 2'b11;

endpackage

// File: rtl/mw_sync.sv
module mw_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] pipe_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) pipe_q[s] <= '0;
    end else begin
      pipe_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) pipe_q[s] <= pipe_q[s-1];
    end
  end

  assign q_o = pipe_q[STAGES-1];

endmodule

// File: rtl/mw_timer.sv
module mw_timer #(
  parameter int CYCLES = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o
);

  localparam int CNT_W = $clog2(CYCLES + 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (start_i)             cnt_q <= CNT_W'(CYCLES);
    else if (cnt_q != '0)         cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);

  // R9
  start_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> busy_o);

  // R9
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> !busy_o);

endmodule

// File: rtl/mw_store.sv
module mw_store
  import mw_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int WORD_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              x16_i,
  input  logic [$clog2(DEPTH):0] rd_addr_i,
  output logic [WORD_W-1:0] rd_data_o,
  input  logic              we_i,
  input  prog_op_e          op_i,
  input  logic [$clog2(DEPTH):0] wr_addr_i,
  input  logic [WORD_W-1:0] wr_data_i
);

  localparam int AW_W   = $clog2(DEPTH);
  localparam int BYTE_W = WORD_W / 2;

  logic [WORD_W-1:0] mem_q [DEPTH];

  logic [AW_W-1:0]   wr_idx, rd_idx;
  logic              wr_hi;
  logic [BYTE_W-1:0] wr_byte, rd_byte;
  logic [WORD_W-1:0] rd_word, fill_word;

  assign wr_idx    = x16_i ? wr_addr_i[AW_W-1:0] : wr_addr_i[AW_W:1];
  assign wr_hi     = wr_addr_i[0];
  assign wr_byte   = wr_data_i[BYTE_W-1:0];
  assign fill_word = x16_i ? wr_data_i : {2{wr_byte}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '1;
    end else if (we_i) begin
      unique case (op_i)
        OP_WRITE: begin
          if (x16_i)      mem_q[wr_idx] <= wr_data_i;
          else if (wr_hi) mem_q[wr_idx][WORD_W-1:BYTE_W] <= wr_byte;
          else            mem_q[wr_idx][BYTE_W-1:0] <= wr_byte;
        end
        OP_ERASE: begin
          if (x16_i)      mem_q[wr_idx] <= '1;
          else if (wr_hi) mem_q[wr_idx][WORD_W-1:BYTE_W] <= '1;
          else            mem_q[wr_idx][BYTE_W-1:0] <= '1;
        end
        OP_WRALL: for (int i = 0; i < DEPTH; i++) mem_q[i] <= fill_word;
        OP_ERAL:  for (int i = 0; i < DEPTH; i++) mem_q[i] <= '1;
        default: ;
      endcase
    end
  end

  // read port is left aligned: x8 bytes come out in the upper half
  assign rd_idx    = x16_i ? rd_addr_i[AW_W-1:0] : rd_addr_i[AW_W:1];
  assign rd_word   = mem_q[rd_idx];
  assign rd_byte   = rd_addr_i[0] ? rd_word[WORD_W-1:BYTE_W] : rd_word[BYTE_W-1:0];
  assign rd_data_o = x16_i ? rd_word : {rd_byte, BYTE_W'(0)};

  // R6
  mem_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> ($stable(mem_q[0]) && $stable(mem_q[DEPTH-1])));

endmodule

// File: rtl/mw_frame.sv
module mw_frame
  import mw_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int WORD_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              x16_i,
  input  logic              cs_i,
  input  logic              sk_i,
  input  logic              din_i,
  input  logic              busy_i,
  input  logic [WORD_W-1:0] rd_data_i,
  output logic [$clog2(DEPTH):0] rd_addr_o,
  output logic              prog_req_o,
  output prog_op_e          prog_op_o,
  output logic [$clog2(DEPTH):0] prog_addr_o,
  output logic [WORD_W-1:0] prog_data_o,
  output logic              dout_o,
  output logic              dout_oe_o
);

  localparam int AW_W   = $clog2(DEPTH);
  localparam int AB_W   = AW_W + 1;
  localparam int BYTE_W = WORD_W / 2;
  localparam int HDR_W  = 2 + AB_W;
  localparam int CNT_W  = $clog2(WORD_W + HDR_W + 1);

  fr_state_e         state_q;
  logic              cs_q, sk_q;
  logic [HDR_W-1:0]  hdr_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              wen_q, pend_q, stat_q, dout_q;
  prog_op_e          pend_op_q;
  logic [AB_W-1:0]   addr_q;
  logic [WORD_W-1:0] dsr_q, osh_q;

  logic              sk_rise, cs_fall;
  logic [HDR_W-1:0]  hdr_n;
  logic [1:0]        opc, sub;
  logic [AB_W-1:0]   adr, addr_nxt;
  logic [CNT_W-1:0]  hdr_len, dat_len, cnt_inc;

  assign sk_rise  = sk_i & ~sk_q;
  assign cs_fall  = cs_q & ~cs_i;
  assign hdr_n    = {hdr_q[HDR_W-2:0], din_i};
  assign opc      = x16_i ? hdr_n[AW_W+1 -: 2] : hdr_n[AB_W+1 -: 2];
  assign sub      = x16_i ? hdr_n[AW_W-1 -: 2] : hdr_n[AB_W-1 -: 2];
  assign adr      = x16_i ? {1'b0, hdr_n[AW_W-1:0]} : hdr_n[AB_W-1:0];
  assign addr_nxt = x16_i ? {1'b0, addr_q[AW_W-1:0] + AW_W'(1)} : addr_q + AB_W'(1);
  assign hdr_len  = x16_i ? CNT_W'(2 + AW_W) : CNT_W'(2 + AB_W);
  assign dat_len  = x16_i ? CNT_W'(WORD_W) : CNT_W'(BYTE_W);
  assign cnt_inc  = cnt_q + 1'b1;

  assign rd_addr_o   = (state_q == ST_HDR) ? adr : addr_nxt;
  assign prog_req_o  = cs_fall & pend_q & wen_q & ~busy_i;
  assign prog_op_o   = pend_op_q;
  assign prog_addr_o = addr_q;
  assign prog_data_o = dsr_q;
  assign dout_oe_o   = cs_i & ((state_q == ST_READ) | stat_q);
  assign dout_o      = stat_q ? ~busy_i : dout_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_WAIT;
      cs_q      <= 1'b0;
      sk_q      <= 1'b0;
      hdr_q     <= '0;
      cnt_q     <= '0;
      wen_q     <= 1'b0;
      pend_q    <= 1'b0;
      pend_op_q <= OP_NONE;
      stat_q    <= 1'b0;
      dout_q    <= 1'b0;
      addr_q    <= '0;
      dsr_q     <= '0;
      osh_q     <= '0;
    end else begin
      cs_q <= cs_i;
      sk_q <= sk_i;

      if (prog_req_o)                    stat_q <= 1'b1;
      else if (sk_rise && cs_i && din_i) stat_q <= 1'b0;

      if (!cs_i) begin
        state_q <= ST_WAIT;
        cnt_q   <= '0;
        pend_q  <= 1'b0;
      end else if (sk_rise) begin
        unique case (state_q)
          ST_WAIT: begin
            // start bit; dropped while a program cycle runs
            if (din_i && !busy_i) begin
              state_q <= ST_HDR;
              cnt_q   <= '0;
              hdr_q   <= '0;
            end
          end
          ST_HDR: begin
            hdr_q <= hdr_n;
            cnt_q <= cnt_inc;
            if (cnt_inc == hdr_len) begin
              cnt_q  <= '0;
              addr_q <= adr;
              dsr_q  <= '0;
              unique case (opc)
                OPC_READ: begin
                  state_q <= ST_READ;
                  osh_q   <= rd_data_i;
                  dout_q  <= 1'b0;
                end
                OPC_WRITE: begin
                  state_q   <= ST_DATA;
                  pend_op_q <= OP_WRITE;
                end
                OPC_ERASE: begin
                  state_q   <= ST_TAIL;
                  pend_op_q <= OP_ERASE;
                  pend_q    <= 1'b1;
                end
                default: begin
                  unique case (sub)
                    SUB_WEN: begin
                      wen_q   <= 1'b1;
                      state_q <= ST_TAIL;
                    end
                    SUB_WDS: begin
                      wen_q   <= 1'b0;
                      state_q <= ST_TAIL;
                    end
                    SUB_WRALL: begin
                      state_q   <= ST_DATA;
                      pend_op_q <= OP_WRALL;
                    end
                    default: begin
                      state_q   <= ST_TAIL;
                      pend_op_q <= OP_ERAL;
                      pend_q    <= 1'b1;
                    end
                  endcase
                end
              endcase
            end
          end
          ST_DATA: begin
            dsr_q <= {dsr_q[WORD_W-2:0], din_i};
            cnt_q <= cnt_inc;
            if (cnt_inc == dat_len) begin
              pend_q  <= 1'b1;
              state_q <= ST_TAIL;
            end
          end
          ST_TAIL: pend_q <= 1'b0;  // surplus bit cancels programming
          ST_READ: begin
            dout_q <= osh_q[WORD_W-1];
            osh_q  <= {osh_q[WORD_W-2:0], 1'b0};
            cnt_q  <= cnt_inc;
            if (cnt_inc == dat_len) begin
              cnt_q  <= '0;
              osh_q  <= rd_data_i;
              addr_q <= addr_nxt;
            end
          end
          default: state_q <= ST_WAIT;
        endcase
      end
    end
  end

  // R7
  prog_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_req_o |-> ($past(cs_i) && !cs_i));

endmodule

// File: rtl/mw_eeprom.sv
module mw_eeprom
  import mw_pkg::*;
#(
  parameter int DEPTH       = 64,
  parameter int WORD_W      = 16,
  parameter int BUSY_CYCLES = 1000,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_i,
  input  logic sk_i,
  input  logic din_i,
  input  logic org_i,
  output logic dout_o,
  output logic dout_oe_o
);

  localparam int AB_W = $clog2(DEPTH) + 1;

  logic [2:0]        bus_s;
  logic              busy;
  logic              prog_req;
  prog_op_e          prog_op;
  logic [AB_W-1:0]   prog_addr, rd_addr;
  logic [WORD_W-1:0] prog_data, rd_data;

  mw_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({cs_i, sk_i, din_i}),
    .q_o    (bus_s)
  );

  mw_frame #(.DEPTH(DEPTH), .WORD_W(WORD_W)) u_frame (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .x16_i       (org_i),
    .cs_i        (bus_s[2]),
    .sk_i        (bus_s[1]),
    .din_i       (bus_s[0]),
    .busy_i      (busy),
    .rd_data_i   (rd_data),
    .rd_addr_o   (rd_addr),
    .prog_req_o  (prog_req),
    .prog_op_o   (prog_op),
    .prog_addr_o (prog_addr),
    .prog_data_o (prog_data),
    .dout_o      (dout_o),
    .dout_oe_o   (dout_oe_o)
  );

  mw_store #(.DEPTH(DEPTH), .WORD_W(WORD_W)) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .x16_i     (org_i),
    .rd_addr_i (rd_addr),
    .rd_data_o (rd_data),
    .we_i      (prog_req),
    .op_i      (prog_op),
    .wr_addr_i (prog_addr),
    .wr_data_i (prog_data)
  );

  mw_timer #(.CYCLES(BUSY_CYCLES)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (prog_req),
    .busy_o  (busy)
  );

endmodule

// File: tb/mw_eeprom_tb.sv
module mw_eeprom_tb;

  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 8;
  localparam int BUSY_CYC   = 1000;
  localparam int DEPTH      = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs = 1'b0, sk = 1'b0, din = 1'b0, org = 1'b1;
  logic dout, dout_oe;

  int n_chk = 0, n_fail = 0;
  bit wen_m = 1'b0, busy_m = 1'b0;
  logic [15:0] model [DEPTH];

  always #(CLK_PERIOD/2) clk = ~clk;

  mw_eeprom #(.DEPTH(DEPTH), .WORD_W(16), .BUSY_CYCLES(BUSY_CYC), .SYNC_STAGES(2)) u_dut (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .cs_i      (cs),
    .sk_i      (sk),
    .din_i     (din),
    .org_i     (org),
    .dout_o    (dout),
    .dout_oe_o (dout_oe)
  );

  function automatic int aw();   return org ? 6 : 7;    endfunction
  function automatic int dw();   return org ? 16 : 8;   endfunction
  function automatic int nloc(); return org ? 64 : 128; endfunction

  function automatic logic [15:0] mget(int a);
    if (org) return model[a];
    return (a % 2 == 1) ? {8'h00, model[a/2][15:8]} : {8'h00, model[a/2][7:0]};
  endfunction

  task automatic mset(int a, logic [15:0] d);
    if (org) model[a] = d;
    else if (a % 2 == 1) model[a/2][15:8] = d[7:0];
    else model[a/2][7:0] = d[7:0];
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bit_out(logic b);
    din = b; sk = 1'b0; tick(HALF);
    sk = 1'b1; tick(HALF);
  endtask

  task automatic send(logic [31:0] v, int n);
    for (int i = n - 1; i >= 0; i--) bit_out(v[i]);
  endtask

  task automatic cs_hi();
    sk = 1'b0; cs = 1'b1; tick(HALF);
  endtask

  task automatic cs_lo();
    sk = 1'b0; cs = 1'b0; din = 1'b0; tick(HALF);
  endtask

  // R3: opcode 00 with top address bits 11 = enable, 00 = disable
  task automatic cmd_wen(bit en, int extra);
    cs_hi();
    send((32'd1 << (2 + aw())) | ((en ? 32'd3 : 32'd0) << (aw() - 2)), 3 + aw());
    repeat (extra) bit_out(1'b0);
    cs_lo();
    wen_m = en;
  endtask

  // kind: 1 write, 2 erase, 3 write-all, 4 erase-all
  // mode: 0 wait out busy, 1 check status display, 2 leave busy running
  task automatic cmd_prog(int kind, int addr, logic [15:0] data, int extra, int mode);
    int op, a;
    bit eff;
    op = 0; a = addr;
    case (kind)
      1: op = 1;
      2: op = 3;
      3: a = 1 << (aw() - 2);
      default: a = 2 << (aw() - 2);
    endcase
    cs_hi();
    send((32'd1 << (2 + aw())) | (32'(op) << aw()) | 32'(a), 3 + aw());
    if (kind == 1 || kind == 3) send({16'h0, data}, dw());
    repeat (extra) bit_out(1'b0);
    cs_lo();
    eff = wen_m && (extra == 0) && !busy_m;
    if (eff) begin
      case (kind)
        1: mset(addr, data);
        2: mset(addr, 16'hFFFF);
        3: for (int i = 0; i < nloc(); i++) mset(i, data);
        default: for (int i = 0; i < nloc(); i++) mset(i, 16'hFFFF);
      endcase
    end
    if (busy_m) begin
      tick(BUSY_CYC + 50);
      busy_m = 1'b0;
    end else if (eff) begin
      case (mode)
        1: begin
          cs_hi();
          check("R9 busy shown", {30'd0, dout_oe, dout}, 32'd2);
          tick(BUSY_CYC);
          check("R9 ready shown", {30'd0, dout_oe, dout}, 32'd3);
          bit_out(1'b1);
          check("R10 status cleared", {31'd0, dout_oe}, 32'd0);
          cs_lo();
        end
        2: busy_m = 1'b1;
        default: tick(BUSY_CYC + 50);
      endcase
    end
  endtask

  task automatic read_seq(string req, int addr, int n, int lead);
    logic [15:0] got;
    cs_hi();
    repeat (lead) bit_out(1'b0);
    send((32'd1 << (2 + aw())) | (32'd2 << aw()) | 32'(addr), 3 + aw());
    check("R4 dummy zero", {30'd0, dout_oe, dout}, 32'd2);
    for (int k = 0; k < n; k++) begin
      got = '0;
      for (int b = 0; b < dw(); b++) begin
        bit_out(1'b0);
        got = {got[14:0], dout};
      end
      check(req, {16'd0, got}, {16'd0, mget((addr + k) % nloc())});
    end
    cs_lo();
    check("R13 released on CS low", {31'd0, dout_oe}, 32'd0);
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) model[i] = 16'hFFFF;
    tick(5);
    rst_n = 1'b1;
    tick(5);
    check("R13 reset oe", {31'd0, dout_oe}, 32'd0);
    read_seq("R13 reset content", 0, 2, 0);

    cmd_prog(1, 5, 16'h1234, 0, 0);         // R6: still disabled
    read_seq("R6 write protected", 5, 1, 0);

    cmd_wen(1'b1, 0);
    cmd_prog(1, 5, 16'hA5C3, 0, 1);         // R7, R9, R10
    read_seq("R7 write data", 5, 1, 0);

    cmd_prog(1, 63, 16'h0F0F, 0, 0);
    cmd_prog(1, 0, 16'h8001, 0, 0);
    read_seq("R5 stream and wrap x16", 62, 3, 0);

    cmd_prog(1, 7, 16'h7777, 1, 0);         // R11: surplus bit
    read_seq("R11 write cancelled", 7, 1, 0);

    cmd_prog(2, 5, 16'h0000, 0, 0);
    read_seq("R8 erase one", 4, 2, 0);

    cmd_prog(1, 9, 16'h1111, 0, 2);
    cmd_prog(1, 10, 16'h2222, 0, 0);        // R12: sent while busy
    read_seq("R12 busy ignores", 9, 2, 0);

    cmd_prog(3, 0, 16'h5A5A, 0, 0);
    read_seq("R3 write-all", 62, 4, 0);

    cmd_prog(4, 0, 16'h0000, 0, 0);
    read_seq("R8 erase-all", 30, 2, 0);

    org = 1'b0;
    cmd_prog(1, 3, 16'h003C, 0, 0);
    cmd_prog(1, 2, 16'h0081, 0, 0);
    read_seq("R2 x8 bytes", 1, 4, 0);
    cmd_prog(1, 127, 16'h0042, 0, 0);
    read_seq("R5 stream and wrap x8", 127, 2, 0);
    org = 1'b1;
    read_seq("R2 byte lanes in x16 word", 1, 1, 0);

    read_seq("R1 leading zeros skipped", 1, 1, 3);

    cmd_wen(1'b0, 2);                       // R11: disable despite surplus bits
    cmd_prog(1, 20, 16'hBEEF, 0, 0);
    read_seq("R11 disable with surplus bits", 20, 1, 0);
    cmd_wen(1'b1, 1);                       // R11: enable despite surplus bit
    cmd_prog(1, 21, 16'hCAFE, 0, 0);
    read_seq("R11 enable with surplus bit", 21, 1, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule